// File: doc/BRIEF.md
# SPI synchronous request sequencer

This block is an SPI master that carries out one synchronous request/response exchange with a radio coprocessor. The coprocessor signals its state on a slave-ready input (`srdy`). A pulse on `start` drops the shared select/master-ready line and waits for the coprocessor to pull `srdy` low. The block then sends the request frame held in a byte buffer. The first buffer byte is the payload length, and it is followed by a 3-byte header and then the payload. The block keeps the select line low and waits for `srdy` to rise. It then reads the response into the same buffer.

The response is read in two steps. The block first clocks out a header of three zero bytes and stores the three returned bytes at buffer positions 0 to 2. The first of those returned bytes gives the payload length. That many further bytes are exchanged, and each one is stored from offset 3 onward. Two waits are bounded by programmable limits: the wait for `srdy` to fall and the wait for `srdy` to rise. Each wait has its own error code. The block reports how many cycles each wait took.

The state machine has eight states:
- IDLE
- WAIT_LOW (select asserted, waiting for `srdy` low)
- REQ_LOAD and REQ_SHIFT (one request byte each pass)
- WAIT_HIGH (waiting for `srdy` high)
- RSP_LOAD and RSP_SHIFT (one response byte each pass)
- FINISH

The transitions are:
- IDLE→WAIT_LOW on `start`.
- WAIT_LOW→REQ_LOAD when the synchronised `srdy` is low.
- WAIT_LOW→FINISH on fall timeout.
- REQ_LOAD→REQ_SHIFT always.
- REQ_SHIFT→REQ_LOAD after a byte that is not the last one.
- REQ_SHIFT→WAIT_HIGH after the last byte.
- WAIT_HIGH→RSP_LOAD when the synchronised `srdy` is high.
- WAIT_HIGH→FINISH on rise timeout.
- RSP_LOAD→RSP_SHIFT always.
- RSP_SHIFT→RSP_LOAD after a byte that is not the last one.
- RSP_SHIFT→FINISH after the last byte.
- FINISH→IDLE always.

Top module: `sreq_sequencer`

## Requirements
- R1: Out of reset: `ss_n`=1, `sclk`=0, `busy`=0, `done`=0, `err_code`=0.
- R2: A `start` sampled in IDLE drives `ss_n` low at that same clock edge. No `sclk` edge occurs until the synchronised `srdy` has been seen low.
- R3: If `srdy` is still high once the fall count equals `cfg_fall_limit`, the block ends with `err_code`=1. In that case `fall_wait` equals the limit, no `sclk` edge has occurred, and `ss_n` returns high.
- R4: The request sends buffer bytes 0 to L+2, where L is buffer byte 0. It uses SPI mode 0 (`sclk` idles low, data sampled on the rising edge, `mosi` changes on the falling edge) and sends each byte MSB first. Bytes received during the request are discarded.
- R5: After the request, `ss_n` stays low while the block waits for `srdy` high. If `srdy` is still low once the rise count equals `cfg_rise_limit`, the block ends with `err_code`=2 and leaves the buffer unchanged.
- R6: The response begins with three 0x00 bytes on `mosi`. The three received bytes are written to buffer addresses 0, 1 and 2.
- R7: If the first response byte P is non-zero, P more bytes are exchanged. Each sends the current buffer byte at address 3+i and stores the received byte there. If P is zero, no payload is exchanged. Addresses above P+2 are never written.
- R8: Each `sclk` high phase and each low phase lasts `cfg_div`+1 system clocks.
- R9: On success `ss_n` returns high, `done` pulses for exactly one cycle and `err_code`=0.
- R10: `srdy` passes through two flops. If `srdy` falls k cycles after `ss_n` falls, `fall_wait` reads k+2. If `srdy` rises m cycles after the last request `sclk` fall is visible, `rise_wait` reads m+1.
- R11: `start` has no effect while `busy`. Exactly one `done` pulse results, and no second exchange follows.
- R12: `err_code`, `fall_wait`, `rise_wait` and the buffer contents hold their values from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one exchange (sampled in IDLE only) |
| cfg_div | input | DIV_W | Half-period of `sclk` minus one, in system clocks |
| cfg_fall_limit | input | CNT_W | Limit for the wait for `srdy` low |
| cfg_rise_limit | input | CNT_W | Limit for the wait for `srdy` high |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 fall timeout, 2 rise timeout |
| fall_wait | output | CNT_W | Cycles spent waiting for `srdy` low |
| rise_wait | output | CNT_W | Cycles spent waiting for `srdy` high |
| buf_addr | output | ADDR_W | Frame buffer byte address |
| buf_rdata | input | 8 | Frame buffer read data (combinational read) |
| buf_we | output | 1 | Frame buffer write strobe |
| buf_wdata | output | 8 | Frame buffer write data |
| ss_n | output | 1 | Shared select / master-ready, active low |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| srdy | input | 1 | Asynchronous slave-ready from the coprocessor |

## Verification
The hardest situations to reach are the two timeout boundaries. There, a single cycle decides whether the exchange succeeds with a wait equal to the limit or fails with an error. The bench's slave model counts cycles from the moment it sees `ss_n` fall, or from the last request clock fall. It then moves `srdy` at an exact offset, so the k+2 and m+1 relations of R10 place the edge one cycle inside or one cycle outside each limit. The slave also returns a distinct byte pattern during the request. This shows that request-phase data never reaches the buffer.

// File: rtl/sreq_pkg.sv
package sreq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_LOW,
        ST_REQ_LOAD,
        ST_REQ_SHIFT,
        ST_WAIT_HIGH,
        ST_RSP_LOAD,
        ST_RSP_SHIFT,
        ST_FINISH
    } sreq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE        = 2'd0,
        ERR_SEL_TIMEOUT = 2'd1,
        ERR_RSP_TIMEOUT = 2'd2
    } sreq_err_t;

    localparam int HDR_BYTES = 3;

endpackage

// File: rtl/srdy_sync.sv
module srdy_sync #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RESET_VAL;
            sync_q <= RESET_VAL;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       tx,
    input  logic [DIV_W-1:0] half_div,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             done,
    output logic [7:0]       rx
);
    logic             active_q;
    logic             sclk_q;
    logic             done_q;
    logic [2:0]       bit_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       tx_q;
    logic [7:0]       rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            done_q   <= 1'b0;
            bit_q    <= '0;
            div_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                tx_q     <= tx;
                bit_q    <= '0;
                div_q    <= '0;
                sclk_q   <= 1'b0;
                active_q <= 1'b1;
            end else if (active_q) begin
                if (div_q == half_div) begin
                    div_q <= '0;
                    if (!sclk_q) begin
                        // rising edge: sample
                        sclk_q <= 1'b1;
                        rx_q   <= {rx_q[6:0], miso};
                    end else begin
                        // falling edge: present next bit
                        sclk_q <= 1'b0;
                        tx_q   <= {tx_q[6:0], 1'b0};
                        bit_q  <= bit_q + 3'd1;
                        if (bit_q == 3'd7) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assign sclk = sclk_q;
    assign mosi = tx_q[7];
    assign done = done_q;
    assign rx   = rx_q;
endmodule

// File: rtl/sreq_sequencer.sv
module sreq_sequencer
    import sreq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [CNT_W-1:0]  cfg_fall_limit,
    input  logic [CNT_W-1:0]  cfg_rise_limit,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code,
    output logic [CNT_W-1:0]  fall_wait,
    output logic [CNT_W-1:0]  rise_wait,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_rdata,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    output logic              ss_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    input  logic              srdy
);
    localparam logic [ADDR_W-1:0] HDR_LAST = ADDR_W'(HDR_BYTES - 1);
    localparam logic [ADDR_W-1:0] HDR_LEN  = ADDR_W'(HDR_BYTES);

    sreq_state_t       state, state_nxt;
    sreq_err_t         err_q;
    logic [ADDR_W-1:0] idx_q, last_q;
    logic [CNT_W-1:0]  fall_lim_q, rise_lim_q, fall_cnt_q, rise_cnt_q;
    logic              ss_q;
    logic              srdy_s;
    logic              sh_go, sh_done;
    logic [7:0]        sh_tx, sh_rx;

    srdy_sync #(.RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (srdy),
        .q_sync  (srdy_s)
    );

    spi_byte_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (sh_go),
        .tx       (sh_tx),
        .half_div (cfg_div),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .done     (sh_done),
        .rx       (sh_rx)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:      if (start) state_nxt = ST_WAIT_LOW;
            ST_WAIT_LOW: begin
                if (!srdy_s)                      state_nxt = ST_REQ_LOAD;
                else if (fall_cnt_q == fall_lim_q) state_nxt = ST_FINISH;
            end
            ST_REQ_LOAD:  state_nxt = ST_REQ_SHIFT;
            ST_REQ_SHIFT: if (sh_done) state_nxt = (idx_q == last_q) ? ST_WAIT_HIGH : ST_REQ_LOAD;
            ST_WAIT_HIGH: begin
                if (srdy_s)                        state_nxt = ST_RSP_LOAD;
                else if (rise_cnt_q == rise_lim_q) state_nxt = ST_FINISH;
            end
            ST_RSP_LOAD:  state_nxt = ST_RSP_SHIFT;
            ST_RSP_SHIFT: if (sh_done) state_nxt = (idx_q == last_q) ? ST_FINISH : ST_RSP_LOAD;
            ST_FINISH:    state_nxt = ST_IDLE;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_q       <= 1'b1;
            idx_q      <= '0;
            last_q     <= '0;
            fall_lim_q <= '0;
            rise_lim_q <= '0;
            fall_cnt_q <= '0;
            rise_cnt_q <= '0;
            err_q      <= ERR_NONE;
        end else begin
            // select is registered from the next state so it never glitches
            ss_q <= (state_nxt == ST_IDLE) || (state_nxt == ST_FINISH);
            unique case (state)
                ST_IDLE: if (start) begin
                    idx_q      <= '0;
                    fall_lim_q <= cfg_fall_limit;
                    rise_lim_q <= cfg_rise_limit;
                    fall_cnt_q <= '0;
                    rise_cnt_q <= '0;
                    err_q      <= ERR_NONE;
                end
                ST_WAIT_LOW: if (srdy_s) begin
                    if (fall_cnt_q == fall_lim_q) err_q <= ERR_SEL_TIMEOUT;
                    else                          fall_cnt_q <= fall_cnt_q + 1'b1;
                end
                ST_REQ_LOAD: if (idx_q == '0) last_q <= ADDR_W'(buf_rdata) + HDR_LAST;
                ST_REQ_SHIFT: if (sh_done) idx_q <= (idx_q == last_q) ? '0 : idx_q + 1'b1;
                ST_WAIT_HIGH: if (!srdy_s) begin
                    if (rise_cnt_q == rise_lim_q) err_q <= ERR_RSP_TIMEOUT;
                    else                          rise_cnt_q <= rise_cnt_q + 1'b1;
                end
                ST_RSP_SHIFT: if (sh_done) begin
                    // byte 0 of the reply carries the payload length
                    if (idx_q == '0) last_q <= ADDR_W'(sh_rx) + HDR_LAST;
                    if (idx_q != last_q) idx_q <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
        ss_n      = ss_q;
        err_code  = err_q;
        fall_wait = fall_cnt_q;
        rise_wait = rise_cnt_q;
        buf_addr  = idx_q;
        buf_wdata = sh_rx;
        buf_we    = (state == ST_RSP_SHIFT) && sh_done;
        sh_go     = (state == ST_REQ_LOAD) || (state == ST_RSP_LOAD);
        if (state == ST_RSP_LOAD && idx_q < HDR_LEN) sh_tx = 8'h00;
        else                                         sh_tx = buf_rdata;
    end
endmodule

// File: rtl/sreq_sequencer_checker.sv
module sreq_sequencer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [1:0] err_code,
    input logic       buf_we,
    input logic       ss_n,
    input logic       sclk,
    input logic       mosi
);
    a_r8_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sclk);

    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_release_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |-> done);

    a_r7_write_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !ss_n);

    a_r12_err_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(err_code));

    a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    a_r11_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind sreq_sequencer sreq_sequencer_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .err_code (err_code),
    .buf_we   (buf_we),
    .ss_n     (ss_n),
    .sclk     (sclk),
    .mosi     (mosi)
);

// File: tb/sreq_sequencer_bench.sv
module sreq_sequencer_bench;
    localparam int AW = 9;
    localparam int CW = 16;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] cfg_div = '0;
    logic [CW-1:0] cfg_fall_limit = '0;
    logic [CW-1:0] cfg_rise_limit = '0;
    logic          busy, done, buf_we, ss_n, sclk, mosi, miso;
    logic [1:0]    err_code;
    logic [CW-1:0] fall_wait, rise_wait;
    logic [AW-1:0] buf_addr;
    logic [7:0]    buf_rdata, buf_wdata;
    logic          srdy = 1'b1;

    sreq_sequencer u_sreq_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_div(cfg_div),
        .cfg_fall_limit(cfg_fall_limit), .cfg_rise_limit(cfg_rise_limit),
        .busy(busy), .done(done), .err_code(err_code),
        .fall_wait(fall_wait), .rise_wait(rise_wait),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we),
        .buf_wdata(buf_wdata), .ss_n(ss_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .srdy(srdy)
    );

    // frame buffer model
    logic [7:0]    mem [0:511];
    logic [7:0]    orig [0:31];
    logic          tb_we = 1'b0;
    logic [AW-1:0] tb_addr = '0;
    logic [7:0]    tb_data = '0;
    assign buf_rdata = mem[buf_addr];
    always @(posedge clk) begin
        if (tb_we)       mem[tb_addr]  <= tb_data;
        else if (buf_we) mem[buf_addr] <= buf_wdata;
    end

    // slave response model
    logic [7:0] rsp_arr [0:15];
    logic       in_rsp = 1'b0;
    int         rsp_base = 0;
    int         total_falls = 0;
    always_comb begin
        int rb;
        rb = total_falls - rsp_base;
        if (in_rsp && rb >= 0 && rb < 128) miso = rsp_arr[rb / 8][7 - (rb % 8)];
        else                               miso = 8'hEE >> (7 - (total_falls % 8));
    end

    // scoreboard: expected MOSI bytes
    logic [7:0] exp_q [$];
    int         mon_chk = 0;
    int         mon_bad = 0;
    logic       clr_stats = 1'b0;
    int         hi_min = 1000;
    int         hi_max = 0;
    logic       sclk_q = 1'b0;
    logic [7:0] mo_sr = '0;
    int         mo_bits = 0;
    int         hi_run = 0;
    always @(negedge clk) begin
        if (clr_stats) begin
            hi_min = 1000;
            hi_max = 0;
        end
        if (rst_n) begin
            if (sclk && !sclk_q) begin
                mo_sr = {mo_sr[6:0], mosi};
                mo_bits++;
                if (mo_bits == 8) begin
                    mo_bits = 0;
                    mon_chk++;
                    if (exp_q.size() == 0) begin
                        mon_bad++;
                        $display("FAIL R4 unexpected mosi byte actual=%0d expected=none", mo_sr);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        if (e != mo_sr) begin
                            mon_bad++;
                            $display("FAIL R4/R6/R7 mosi byte actual=%0d expected=%0d", mo_sr, e);
                        end
                    end
                end
            end
            if (!sclk && sclk_q) begin
                total_falls++;
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
            end
            if (sclk) hi_run = sclk_q ? hi_run + 1 : 1;
            sclk_q = sclk;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic preload(input int req_len, input int seed);
        for (int i = 0; i < 32; i++) begin
            orig[i] = (i == 0) ? 8'(req_len) : 8'(seed + i * 37);
            tick();
            tb_we   = 1'b1;
            tb_addr = AW'(i);
            tb_data = orig[i];
        end
        tick();
        tb_we = 1'b0;
    endtask

    task automatic slave(input int n_fall, input int m_rise, input int req_bytes);
        int  base;
        bit  gone;
        while (ss_n) tick();
        base = total_falls;
        gone = 1'b0;
        for (int k = 0; k < n_fall; k++) begin
            tick();
            if (ss_n) begin gone = 1'b1; break; end
        end
        if (!gone) begin
            srdy = 1'b0;
            while (!ss_n && (total_falls - base) < 8 * req_bytes) tick();
            if (!ss_n) begin
                for (int k = 0; k < m_rise; k++) begin
                    tick();
                    if (ss_n) begin gone = 1'b1; break; end
                end
                if (!gone) begin
                    rsp_base = total_falls;
                    in_rsp   = 1'b1;
                    srdy     = 1'b1;
                end
            end
        end
        while (!ss_n) tick();
        srdy   = 1'b1;
        in_rsp = 1'b0;
    endtask

    int       got_done;
    int       got_err;
    longint   got_fw, got_rw;

    task automatic drive(input bit dbl_start);
        int cyc;
        tick();
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(ss_n == 1'b0, "R2 select low after start", ss_n, 0);
        got_done = 0;
        cyc = 0;
        while (got_done == 0 && cyc < 20000) begin
            if (dbl_start && cyc == 10) start = 1'b1;
            if (dbl_start && cyc == 11) start = 1'b0;
            if (done) begin
                got_done++;
                got_err = err_code;
                got_fw  = fall_wait;
                got_rw  = rise_wait;
            end
            tick();
            cyc++;
        end
        for (int k = 0; k < 6; k++) begin
            if (done) got_done++;
            tick();
        end
    endtask

    task automatic run_txn(input int req_len, input int rsp_len, input int n_fall, input int m_rise,
                           input int fl, input int rl, input int div, input int exp_err,
                           input bit dbl_start);
        logic [7:0] exp_mem [0:31];
        int         falls0;
        cfg_div        = DW'(div);
        cfg_fall_limit = CW'(fl);
        cfg_rise_limit = CW'(rl);
        preload(req_len, 11 + req_len * 5 + rsp_len);
        rsp_arr[0] = 8'(rsp_len);
        for (int i = 1; i < 16; i++) rsp_arr[i] = 8'(8'hC3 ^ (i * 29));
        for (int i = 0; i < 32; i++) exp_mem[i] = orig[i];
        if (exp_err != 1) for (int i = 0; i < req_len + 3; i++) exp_q.push_back(orig[i]);
        if (exp_err == 0) begin
            for (int i = 0; i < 3; i++) exp_q.push_back(8'h00);
            for (int i = 3; i < rsp_len + 3; i++) exp_q.push_back(orig[i]);
            for (int i = 0; i < rsp_len + 3; i++) exp_mem[i] = rsp_arr[i];
        end
        clr_stats = 1'b1;
        tick();
        clr_stats = 1'b0;
        falls0 = total_falls;
        fork
            slave(n_fall, m_rise, req_len + 3);
            drive(dbl_start);
        join
        chk(got_done == 1, "R9/R11 done pulse count", got_done, 1);
        chk(got_err == exp_err, "R3/R5/R9 error code", got_err, exp_err);
        chk(ss_n == 1'b1 && busy == 1'b0, "R9/R11 idle after done", {ss_n, busy}, 2);
        chk(err_code == 2'(exp_err), "R12 error code held", err_code, exp_err);
        chk(exp_q.size() == 0, "R4 all expected bytes sent", exp_q.size(), 0);
        exp_q.delete();
        if (exp_err == 0) begin
            chk(got_fw == n_fall + 2, "R10 fall wait", got_fw, n_fall + 2);
            chk(got_rw == m_rise + 1, "R10 rise wait", got_rw, m_rise + 1);
            chk(hi_min == div + 1 && hi_max == div + 1, "R8 sclk high phase", hi_max, div + 1);
        end
        if (exp_err == 1) begin
            chk(total_falls == falls0, "R3 no clocking on fall timeout", total_falls - falls0, 0);
            chk(got_fw == fl, "R3 fall wait at limit", got_fw, fl);
        end
        if (exp_err == 2) chk(got_rw == rl, "R5 rise wait at limit", got_rw, rl);
        for (int i = 0; i < 32; i++)
            chk(mem[i] == exp_mem[i], "R6/R7/R5 buffer byte", mem[i], exp_mem[i]);
        chk(fall_wait == CW'(got_fw) && rise_wait == CW'(got_rw), "R12 waits held", fall_wait, got_fw);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ss_n == 1'b1, "R1 ss_n in reset", ss_n, 1);
        chk(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done in reset", {busy, done}, 0);
        chk(err_code == 2'd0, "R1 err in reset", err_code, 0);
        rst_n = 1'b1;
        tick();
        // normal exchange
        run_txn(2, 4, 3, 4, 20, 20, 1, 0, 1'b0);
        // zero-length request and reply, fastest clock
        run_txn(0, 0, 0, 0, 10, 10, 0, 0, 1'b0);
        // R3 fall timeout: one cycle too late
        run_txn(3, 2, 5, 0, 6, 10, 1, 1, 1'b0);
        // R10 fall boundary: wait equals limit
        run_txn(3, 2, 4, 2, 6, 10, 1, 0, 1'b0);
        // R5 rise timeout
        run_txn(1, 3, 1, 8, 10, 5, 1, 2, 1'b0);
        // R10 rise boundary
        run_txn(1, 3, 1, 4, 10, 5, 1, 0, 1'b0);
        // R11 start while busy, R8 slower clock, long payload
        run_txn(1, 13, 2, 3, 10, 10, 3, 0, 1'b1);
        n_chk += mon_chk;
        n_bad += mon_bad;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk + mon_chk + 1, n_bad + mon_bad + 1);
            $finish;
        end
    end
endmodule